// File: doc/BRIEF.md
# Power Switch Sequencer

The block brings memory power domains up for a group of cores. Each core has two domains, the core memory and the wrapper memory. Each domain has a four-bit power-switch enable vector and a matching four-bit status vector. After a start strobe, the block first releases a subsystem-level reset. It then visits the cores in ascending index order and skips every core whose bit is clear in the enable mask latched at start.

For each enabled core, the block steps through the core-memory domain first and the wrapper-memory domain second. In each domain it turns on one switch bit per stage and keeps the earlier bits on. A stage only moves on when the status input shows the bit it has just turned on. The status is checked once on entering the stage and then once per millisecond tick. If the bit is still missing after the allowed number of checks, the whole run stops with an error that names the core and the stage.

When both domains of a core are up, its two isolation outputs drop together. The core's active-low soft reset is then pulsed low for a timed interval. After the last enabled core, a one-cycle done pulse marks success.

Top module: `pwr_switch_seq`

## Requirements
- R1: While synchronous reset is applied, all switch enables are 0, both isolation outputs of every core are 1, every soft reset output is 1, the subsystem reset output is 0, and busy, done and error are 0.
- R2: A start strobe sets the subsystem reset output to 1 before any switch enable bit turns on. The output stays 1 afterwards.
- R3: Within a domain, the enable vector grows only through 0000, 1000, 1100, 1110, 1111. The bits turn on in the order bit 3, bit 2, bit 1, bit 0, and earlier bits stay on.
- R4: A stage advances only after the status bit at the same position as that stage's enable bit has been seen as 1. Status bits at other positions do not advance it.
- R5: A stage whose status bit is not seen at any of its TIMEOUT_MS checks ends the run with error = 1 and no done pulse. The checks happen at stage entry and then every US_PER_MS*CYC_PER_US cycles. After the error, no further enable, isolation or reset output of any core changes. A status bit that arrives before the last check lets the stage pass.
- R6: The wrapper-memory enables of a core stay 0 until all four core-memory enables of that core are 1.
- R7: A core's two isolation outputs drop to 0 in the same cycle, and only once both of its domains read 1111.
- R8: After isolation drops, the core's soft reset goes low for exactly RST_US*CYC_PER_US cycles and then returns high. Isolation is already 0 during the whole low interval.
- R9: Enabled cores are powered in ascending index order. Cores whose mask bit is 0 keep all-zero enables, isolation 1 and soft reset 1.
- R10: After the last enabled core finishes, done is 1 for exactly one cycle, including when the mask is all zero.
- R11: A start strobe that arrives while busy is 1 is ignored, together with the mask presented with it.
- R12: On error, err_core_o gives the failing core index. err_stage_o gives {domain, stage}, where domain 0 is core memory and 1 is wrapper memory, and stage 0 to 3 stands for enable bits 3 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, honoured only while idle |
| en_mask_i | input | NUM_CORES | Cores to power, sampled at start |
| core_ack_i | input | 4*NUM_CORES | Core-memory switch status, 4 bits per core |
| wrap_ack_i | input | 4*NUM_CORES | Wrapper-memory switch status, 4 bits per core |
| ss_rst_n_o | output | 1 | Subsystem reset, active low |
| core_sw_o | output | 4*NUM_CORES | Core-memory switch enables, 4 bits per core |
| wrap_sw_o | output | 4*NUM_CORES | Wrapper-memory switch enables, 4 bits per core |
| core_iso_o | output | NUM_CORES | Core logic isolation, 1 = isolated |
| mem_iso_o | output | NUM_CORES | Memory isolation, 1 = isolated |
| soft_rst_n_o | output | NUM_CORES | Per-core soft reset, active low |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse on success |
| err_o | output | 1 | Run aborted on a stage timeout; held until next start |
| err_core_o | output | max(1,clog2(NUM_CORES)) | Index of the failing core |
| err_stage_o | output | 3 | {domain, stage} of the failing step |

## Verification
The switch status inputs come from a bench model that acknowledges each enable bit after a delay set per core. Some runs add a stuck bit, and one run forces the other status bits high. The masks tried are all cores, alternating cores, a single core and no cores. These separate ordering, skipping and the empty-run done pulse. Status delays well inside the check window and well beyond the last check show the timeout boundary from both sides. A stuck bit on the wrapper domain of a middle core, and a stuck bit on the first stage with all other status bits forced high, pin down the error encoding and show that a wrong-position status bit does not advance a stage. A second start during a run, and a reset in the middle of a run, cover the ignore and return-to-off rules.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_SCAN,
      S_SET,
      S_WAIT,
      S_ISO,
      S_RSTLO,
      S_RSTHOLD
   } seq_state_t;

   localparam int SW_BITS = 4;

   // stage 0 drives bit 3, stage 3 drives bit 0
   function automatic logic [1:0] stage_to_bit(input logic [1:0] stg);
      return ~stg;
   endfunction
endpackage

// File: rtl/pss_cycle_timer.sv
module pss_cycle_timer #(
   parameter int PERIOD = 8,
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD + 1) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic tick_o
);
   logic [CW-1:0] cnt;

   generate
      if (PERIOD < 1) begin : g_bad_period
         $error("pss_cycle_timer: PERIOD must be at least 1");
      end
   endgenerate

   assign tick_o = en && !clr && (cnt == CW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= tick_o ? '0 : cnt + 1'b1;
      end
   end

   p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
      !clr |=> (cnt < CW'(PERIOD)))
      else $error("timer count out of range");
endmodule

// File: rtl/pss_ack_check.sv
module pss_ack_check #(
   parameter int TIMEOUT_MS = 5,
   localparam int TW = $clog2(TIMEOUT_MS + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic active,
   input  logic ms_tick,
   input  logic ack,
   output logic pass_o,
   output logic fail_o
);
   logic          due;
   logic [TW-1:0] tries;
   logic          check_now;

   generate
      if (TIMEOUT_MS < 1) begin : g_bad_timeout
         $error("pss_ack_check: TIMEOUT_MS must be at least 1");
      end
   endgenerate

   assign check_now = active && (due || ms_tick);
   assign pass_o    = check_now && ack;
   assign fail_o    = check_now && !ack && (tries == TW'(TIMEOUT_MS - 1));

   always_ff @(posedge clk) begin
      if (rst || arm) begin
         due   <= arm;
         tries <= '0;
      end else if (check_now) begin
         due <= 1'b0;
         if (!ack) tries <= tries + 1'b1;
      end
   end

   p_tries_cap_r5: assert property (@(posedge clk) disable iff (rst)
      active |-> (tries < TW'(TIMEOUT_MS)))
      else $error("stage waited beyond its check budget");

   p_verdict_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(pass_o && fail_o))
      else $error("pass and fail together");
endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq
   import pss_pkg::*;
#(
   parameter int NUM_CORES  = 4,
   parameter int CYC_PER_US = 100,
   parameter int US_PER_MS  = 1000,
   parameter int TIMEOUT_MS = 5,
   parameter int RST_US     = 1,
   localparam int CIW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start_i,
   input  logic [NUM_CORES-1:0]   en_mask_i,
   input  logic [NUM_CORES*4-1:0] core_ack_i,
   input  logic [NUM_CORES*4-1:0] wrap_ack_i,
   output logic                   ss_rst_n_o,
   output logic [NUM_CORES*4-1:0] core_sw_o,
   output logic [NUM_CORES*4-1:0] wrap_sw_o,
   output logic [NUM_CORES-1:0]   core_iso_o,
   output logic [NUM_CORES-1:0]   mem_iso_o,
   output logic [NUM_CORES-1:0]   soft_rst_n_o,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   err_o,
   output logic [CIW-1:0]         err_core_o,
   output logic [2:0]             err_stage_o
);
   localparam int IDXW     = $clog2(NUM_CORES + 1);
   localparam int MS_CYC   = CYC_PER_US * US_PER_MS;
   localparam int HOLD_CYC = CYC_PER_US * RST_US;

   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("pwr_switch_seq: NUM_CORES must be at least 1");
      end
      if (CYC_PER_US < 1 || US_PER_MS < 1 || RST_US < 1) begin : g_bad_timing
         $error("pwr_switch_seq: timing parameters must be positive");
      end
   endgenerate

   seq_state_t             st;
   logic [IDXW-1:0]        idx;
   logic [CIW-1:0]         cur;
   logic                   dom;
   logic [1:0]             stg;
   logic [NUM_CORES-1:0]   mask_q;
   logic [3:0]             core_sw [NUM_CORES];
   logic [3:0]             wrap_sw [NUM_CORES];
   logic [NUM_CORES-1:0]   ciso, miso, srst_n;
   logic                   ss_rst_n_q, done_q, err_q;
   logic [CIW-1:0]         err_core_q;
   logic [2:0]             err_stage_q;
   logic [3:0]             ack_vec;
   logic                   ack_bit;
   logic                   ms_tick, hold_tick, stage_pass, stage_fail;

   assign cur     = idx[CIW-1:0];
   assign ack_vec = dom ? wrap_ack_i[int'(cur)*4 +: 4] : core_ack_i[int'(cur)*4 +: 4];
   assign ack_bit = ack_vec[stage_to_bit(stg)];

   pss_cycle_timer #(.PERIOD(MS_CYC)) i_ms_timer (
      .clk(clk), .rst(rst), .clr(st == S_SET), .en(st == S_WAIT), .tick_o(ms_tick)
   );

   pss_cycle_timer #(.PERIOD(HOLD_CYC)) i_hold_timer (
      .clk(clk), .rst(rst), .clr(st == S_RSTLO), .en(st == S_RSTHOLD), .tick_o(hold_tick)
   );

   pss_ack_check #(.TIMEOUT_MS(TIMEOUT_MS)) i_ack_check (
      .clk(clk), .rst(rst), .arm(st == S_SET), .active(st == S_WAIT),
      .ms_tick(ms_tick), .ack(ack_bit), .pass_o(stage_pass), .fail_o(stage_fail)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st          <= S_IDLE;
         idx         <= '0;
         dom         <= 1'b0;
         stg         <= '0;
         mask_q      <= '0;
         ciso        <= '1;
         miso        <= '1;
         srst_n      <= '1;
         ss_rst_n_q  <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         err_core_q  <= '0;
         err_stage_q <= '0;
         for (int c = 0; c < NUM_CORES; c++) begin
            core_sw[c] <= '0;
            wrap_sw[c] <= '0;
         end
      end else begin
         done_q <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start_i) begin
                  mask_q     <= en_mask_i;
                  idx        <= '0;
                  ss_rst_n_q <= 1'b1;
                  err_q      <= 1'b0;
                  st         <= S_SCAN;
               end
            end
            S_SCAN: begin
               if (idx == IDXW'(NUM_CORES)) begin
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end else if (mask_q[cur]) begin
                  dom <= 1'b0;
                  stg <= '0;
                  st  <= S_SET;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_SET: begin
               if (dom) wrap_sw[cur][stage_to_bit(stg)] <= 1'b1;
               else     core_sw[cur][stage_to_bit(stg)] <= 1'b1;
               st <= S_WAIT;
            end
            S_WAIT: begin
               if (stage_fail) begin
                  err_q       <= 1'b1;
                  err_core_q  <= cur;
                  err_stage_q <= {dom, stg};
                  st          <= S_IDLE;
               end else if (stage_pass) begin
                  if (stg != 2'd3) begin
                     stg <= stg + 1'b1;
                     st  <= S_SET;
                  end else if (!dom) begin
                     dom <= 1'b1;
                     stg <= '0;
                     st  <= S_SET;
                  end else begin
                     st <= S_ISO;
                  end
               end
            end
            S_ISO: begin
               ciso[cur] <= 1'b0;
               miso[cur] <= 1'b0;
               st        <= S_RSTLO;
            end
            S_RSTLO: begin
               srst_n[cur] <= 1'b0;
               st          <= S_RSTHOLD;
            end
            S_RSTHOLD: begin
               if (hold_tick) begin
                  srst_n[cur] <= 1'b1;
                  idx         <= idx + 1'b1;
                  st          <= S_SCAN;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign ss_rst_n_o   = ss_rst_n_q;
   assign core_iso_o   = ciso;
   assign mem_iso_o    = miso;
   assign soft_rst_n_o = srst_n;
   assign busy_o       = (st != S_IDLE);
   assign done_o       = done_q;
   assign err_o        = err_q;
   assign err_core_o   = err_core_q;
   assign err_stage_o  = err_stage_q;

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         assign core_sw_o[c*4 +: 4] = core_sw[c];
         assign wrap_sw_o[c*4 +: 4] = wrap_sw[c];

         p_core_grow_r3: assert property (@(posedge clk) disable iff (rst)
            (core_sw[c] != $past(core_sw[c])) |->
               (core_sw[c] == ($past(core_sw[c]) | ($past(core_sw[c]) >> 1) | 4'b1000)))
            else $error("core-memory enables left the stage order");

         p_wrap_grow_r3: assert property (@(posedge clk) disable iff (rst)
            (wrap_sw[c] != $past(wrap_sw[c])) |->
               (wrap_sw[c] == ($past(wrap_sw[c]) | ($past(wrap_sw[c]) >> 1) | 4'b1000)))
            else $error("wrapper-memory enables left the stage order");

         for (genvar b = 0; b < 3; b++) begin : g_bit
            p_core_adv_ack_r4: assert property (@(posedge clk) disable iff (rst)
               $rose(core_sw_o[c*4+b]) |-> $past(core_ack_i[c*4+b+1], 2))
               else $error("core stage advanced without its status bit");
            p_wrap_adv_ack_r4: assert property (@(posedge clk) disable iff (rst)
               $rose(wrap_sw_o[c*4+b]) |-> $past(wrap_ack_i[c*4+b+1], 2))
               else $error("wrapper stage advanced without its status bit");
         end

         p_wrap_after_core_r6: assert property (@(posedge clk) disable iff (rst)
            (|wrap_sw_o[c*4 +: 4]) |-> (core_sw_o[c*4 +: 4] == 4'hF))
            else $error("wrapper domain started before core domain finished");

         p_iso_needs_pwr_r7: assert property (@(posedge clk) disable iff (rst)
            (!core_iso_o[c] || !mem_iso_o[c]) |->
               (core_sw_o[c*4 +: 4] == 4'hF && wrap_sw_o[c*4 +: 4] == 4'hF))
            else $error("isolation released on an unpowered core");

         p_rst_after_iso_r8: assert property (@(posedge clk) disable iff (rst)
            !soft_rst_n_o[c] |-> (!core_iso_o[c] && !mem_iso_o[c]))
            else $error("soft reset pulsed while isolated");
      end
   endgenerate

   p_ss_first_r2: assert property (@(posedge clk) disable iff (rst)
      ((|core_sw_o) || (|wrap_sw_o)) |-> ss_rst_n_o)
      else $error("switch enabled with subsystem still in reset");

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o)
      else $error("done held longer than one cycle");

   p_err_no_done_r5: assert property (@(posedge clk) disable iff (rst)
      err_o |-> !done_o)
      else $error("done pulsed on an aborted run");

   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i) |=> $stable(mask_q))
      else $error("start accepted while busy");
endmodule

// File: tb/test_pwr_switch_seq.sv
module test_pwr_switch_seq;
   localparam int NC   = 4;
   localparam int CPU  = 2;
   localparam int UPM  = 4;
   localparam int TMO  = 5;
   localparam int RUS  = 3;
   localparam int HOLD = CPU * RUS;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            start = 1'b0;
   logic [NC-1:0]   en_mask = '0;
   logic [NC*4-1:0] core_ack, wrap_ack;
   logic            ss_rst_n, busy, done, err;
   logic [NC*4-1:0] core_sw, wrap_sw;
   logic [NC-1:0]   core_iso, mem_iso, srst_n;
   logic [1:0]      err_core;
   logic [2:0]      err_stage;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwr_switch_seq #(.NUM_CORES(NC), .CYC_PER_US(CPU), .US_PER_MS(UPM),
                    .TIMEOUT_MS(TMO), .RST_US(RUS)) i_pwr_switch_seq (
      .clk(clk), .rst(rst), .start_i(start), .en_mask_i(en_mask),
      .core_ack_i(core_ack), .wrap_ack_i(wrap_ack), .ss_rst_n_o(ss_rst_n),
      .core_sw_o(core_sw), .wrap_sw_o(wrap_sw), .core_iso_o(core_iso),
      .mem_iso_o(mem_iso), .soft_rst_n_o(srst_n), .busy_o(busy), .done_o(done),
      .err_o(err), .err_core_o(err_core), .err_stage_o(err_stage)
   );

   // switch model: status bit follows its enable after dly[core] cycles
   int dly [NC];
   int blk_core = -1, blk_dom = 0, blk_bit = 0;
   logic blk_force = 1'b0;
   int cc [NC*4];
   int wc [NC*4];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NC*4; i++) begin
         cc[i] <= core_sw[i] ? ((cc[i] < 1000) ? cc[i] + 1 : cc[i]) : 0;
         wc[i] <= wrap_sw[i] ? ((wc[i] < 1000) ? wc[i] + 1 : wc[i]) : 0;
      end
   end

   always_comb begin
      for (int i = 0; i < NC*4; i++) begin
         core_ack[i] = (cc[i] >= dly[i/4]) && core_sw[i];
         wrap_ack[i] = (wc[i] >= dly[i/4]) && wrap_sw[i];
         if (blk_core == i/4) begin
            if (blk_dom == 0) begin
               if (i%4 == blk_bit) core_ack[i] = 1'b0;
               else if (blk_force) core_ack[i] = 1'b1;
            end else begin
               if (i%4 == blk_bit) wrap_ack[i] = 1'b0;
               else if (blk_force) wrap_ack[i] = 1'b1;
            end
         end
      end
   end

   // monitor
   logic mon_clr = 1'b1;
   int bad_grow, bad_wrap, bad_iso, bad_ss, bad_done, done_cnt, ord_n;
   int ord [8];
   int low_run [NC];
   int last_len [NC];
   logic [3:0] pc [NC];
   logic [3:0] pw [NC];
   logic prev_done;

   always @(negedge clk) begin
      if (mon_clr) begin
         bad_grow = 0; bad_wrap = 0; bad_iso = 0; bad_ss = 0; bad_done = 0;
         done_cnt = 0; ord_n = 0; prev_done = 1'b0;
         for (int c = 0; c < NC; c++) begin
            low_run[c] = 0; last_len[c] = 0; pc[c] = '0; pw[c] = '0;
         end
      end else begin
         for (int c = 0; c < NC; c++) begin
            logic [3:0] cs, ws;
            cs = core_sw[c*4 +: 4];
            ws = wrap_sw[c*4 +: 4];
            if (cs != pc[c] && cs != (pc[c] | (pc[c] >> 1) | 4'h8)) bad_grow++;
            if (ws != pw[c] && ws != (pw[c] | (pw[c] >> 1) | 4'h8)) bad_grow++;
            if (pc[c] == 0 && cs != 0 && ord_n < 8) begin ord[ord_n] = c; ord_n++; end
            if (ws != 0 && cs != 4'hF) bad_wrap++;
            if (core_iso[c] != mem_iso[c]) bad_iso++;
            if (!core_iso[c] && !(cs == 4'hF && ws == 4'hF)) bad_iso++;
            if (!srst_n[c]) begin
               low_run[c]++;
               if (core_iso[c]) bad_iso++;
            end else if (low_run[c] != 0) begin
               last_len[c] = low_run[c];
               low_run[c] = 0;
            end
            pc[c] = cs;
            pw[c] = ws;
         end
         if ((core_sw != 0 || wrap_sw != 0) && !ss_rst_n) bad_ss++;
         if (done) begin
            done_cnt++;
            if (prev_done) bad_done++;
         end
         prev_done = done;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      mon_clr = 1'b1;
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      mon_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_start(input logic [NC-1:0] m);
      en_mask = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk("R5 run finished", int'(busy), 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_off();
      chk("R1 core enables off", int'(core_sw), 0);
      chk("R1 wrapper enables off", int'(wrap_sw), 0);
      chk("R1 core isolation on", int'(core_iso), 4'hF);
      chk("R1 memory isolation on", int'(mem_iso), 4'hF);
      chk("R1 soft reset idle high", int'(srst_n), 4'hF);
      chk("R1 subsystem in reset", int'(ss_rst_n), 0);
      chk("R1 busy low", int'(busy), 0);
      chk("R1 done low", int'(done), 0);
      chk("R1 error low", int'(err), 0);
   endtask

   task automatic check_common();
      chk("R3 enable growth order", bad_grow, 0);
      chk("R6 wrapper after core", bad_wrap, 0);
      chk("R7 isolation pairing and power", bad_iso, 0);
      chk("R2 subsystem reset released first", bad_ss, 0);
      chk("R2 subsystem reset high", int'(ss_rst_n), 1);
      chk("R10 done single cycle", bad_done, 0);
   endtask

   task automatic check_ok(input logic [NC-1:0] m);
      int k = 0;
      check_common();
      chk("R10 done pulse count", done_cnt, 1);
      chk("R5 no error on success", int'(err), 0);
      for (int c = 0; c < NC; c++) begin
         chk("R9 core enables", int'(core_sw[c*4 +: 4]), m[c] ? 15 : 0);
         chk("R9 wrapper enables", int'(wrap_sw[c*4 +: 4]), m[c] ? 15 : 0);
         chk("R7 isolation state", int'(core_iso[c]), m[c] ? 0 : 1);
         chk("R8 soft reset high", int'(srst_n[c]), 1);
         chk("R8 soft reset low length", last_len[c], m[c] ? HOLD : 0);
         if (m[c]) begin
            chk("R9 ascending order", (k < ord_n) ? ord[k] : -1, c);
            k++;
         end
      end
      chk("R9 enabled core count", ord_n, k);
   endtask

   task automatic check_err(input int fcore, input int fstage,
                            input logic [NC*4-1:0] exp_core, input logic [NC*4-1:0] exp_wrap,
                            input logic [NC-1:0] exp_iso);
      check_common();
      chk("R5 error raised", int'(err), 1);
      chk("R5 no done on error", done_cnt, 0);
      chk("R12 failing core", int'(err_core), fcore);
      chk("R12 failing stage code", int'(err_stage), fstage);
      chk("R5 core enables frozen", int'(core_sw), int'(exp_core));
      chk("R5 wrapper enables frozen", int'(wrap_sw), int'(exp_wrap));
      chk("R5 isolation frozen", int'(core_iso), int'(exp_iso));
      chk("R5 soft resets idle", int'(srst_n), 4'hF);
      repeat (60) @(negedge clk);
      chk("R5 nothing moves after error", int'(core_sw), int'(exp_core));
      chk("R5 wrapper still after error", int'(wrap_sw), int'(exp_wrap));
   endtask

   initial begin
      for (int c = 0; c < NC; c++) dly[c] = 3;

      do_reset();
      check_off();

      // all cores
      do_reset();
      pulse_start(4'b1111);
      wait_idle();
      check_ok(4'b1111);

      // alternating cores, varied delays
      dly[1] = 20; dly[3] = 5;
      do_reset();
      pulse_start(4'b1010);
      wait_idle();
      check_ok(4'b1010);
      for (int c = 0; c < NC; c++) dly[c] = 3;

      // empty mask
      do_reset();
      pulse_start(4'b0000);
      wait_idle();
      check_ok(4'b0000);

      // stuck wrapper bit 1 on core 2 -> stage code {1,2}
      blk_core = 2; blk_dom = 1; blk_bit = 1; blk_force = 1'b0;
      do_reset();
      pulse_start(4'b1111);
      wait_idle();
      check_err(2, 6, 16'h0FFF | 16'h0F00, 16'h0EFF, 4'b1100);

      // stuck first-stage bit on core 0 with other status bits forced high (R4)
      blk_core = 0; blk_dom = 0; blk_bit = 3; blk_force = 1'b1;
      do_reset();
      pulse_start(4'b1111);
      wait_idle();
      check_err(0, 0, 16'h0008, 16'h0000, 4'b1111);
      blk_core = -1; blk_force = 1'b0;

      // late status inside the window passes (R5 boundary)
      dly[3] = 26;
      do_reset();
      pulse_start(4'b1000);
      wait_idle();
      check_ok(4'b1000);

      // status beyond the last check fails
      dly[3] = 45;
      do_reset();
      pulse_start(4'b1000);
      wait_idle();
      check_err(3, 0, 16'h8000, 16'h0000, 4'b1111);
      dly[3] = 3;

      // second start while busy is ignored (R11)
      do_reset();
      pulse_start(4'b0001);
      repeat (4) @(negedge clk);
      chk("R11 busy during run", int'(busy), 1);
      pulse_start(4'b1111);
      wait_idle();
      check_ok(4'b0001);

      // reset in mid-run returns outputs to off (R1)
      do_reset();
      pulse_start(4'b1111);
      repeat (30) @(negedge clk);
      rst = 1'b1;
      mon_clr = 1'b1;
      repeat (2) @(negedge clk);
      check_off();
      rst = 1'b0;
      mon_clr = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule